// File: doc/BRIEF.md
# Global Activation Throttle Controller

This block watches DRAM row activations rank by rank over a long global window and picks how hard a memory channel is throttled. Each rank has its own activation counter. At the last cycle of every global window the counts are compared with a programmable limit. If any rank went past the limit, a sticky global-throttle status is raised, and a select output tells the downstream activation throttler to use its high (stricter) limit instead of its low one.

Once raised, the status works as hysteresis. It drops only after a set number of back-to-back global windows in which no rank passed the limit. That number is 16, or 2 when a mode input asks for the short hold. An over-limit window during that run restarts the run from zero. All timing comes from the core clock. A free-running divider makes a base window of 1344 core cycles, and the global window is a whole number of base windows (nominally 16384). Short peaks in traffic therefore cannot push the channel into high throttling. Only sustained activity over the long window can.

Top module: `gact_throttle`

## Requirements
- R1: While reset is asserted, and right after it is released, `gbl_throttle` and `use_high_limit` are 0, and every rank counter, the clean-window run count and the window timer start from zero.
- R2: A global window lasts BASE_CYCLES × GLOBAL_BASES core clock cycles, counted from the first clock edge after the internal reset is released. `gbl_throttle` changes only in the cycle that follows the last cycle of a window.
- R3: Each rank counter counts one activation for every cycle in which that rank's `act_pulse` bit is 1. This includes the last cycle of a window, which still counts toward that window.
- R4: When any rank's count is strictly greater than `act_limit` at the end of a window, `gbl_throttle` is 1 from the next cycle on, even if it was 0 before.
- R5: A count exactly equal to `act_limit` does not count as over the limit.
- R6: A rank counter stops at its all-ones value (2^CNT_W − 1) and does not wrap, so a saturated counter still reads as over any smaller limit.
- R7: All rank counters return to zero at each window boundary, so activations never carry into the next window.
- R8: With `short_hold` = 0, a set status clears at the end of the 16th consecutive window with no rank over the limit.
- R9: With `short_hold` = 1, a set status clears at the end of the 2nd consecutive clean window. `short_hold` and `act_limit` are sampled at each window end.
- R10: An over-limit window while the status is set resets the clean-window run to zero, and the full hold count must elapse again.
- R11: `use_high_limit` is 1 exactly when `gbl_throttle` is 1 (1 = high throttle limit, 0 = low throttle limit).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; all window timing counts this clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| act_pulse | input | NUM_RANKS | One bit per rank, 1 for each cycle carrying a row activation to that rank |
| act_limit | input | CNT_W | Activation limit per rank per global window |
| short_hold | input | 1 | 1 selects a 2-window hold, 0 a 16-window hold |
| gbl_throttle | output | 1 | Sticky global-throttle status |
| use_high_limit | output | 1 | Throttle limit select: 1 high, 0 low |

## Verification
Two events can land in the same cycle. The first is the window-end compare-and-clear of the rank counters. The second is an activation pulse arriving in that same final cycle, which must be counted toward the closing window and must not leak into the next one. The bench provokes this by placing a rank's pulses at the very tail of a window, so the count goes over the limit only if the final-cycle pulse is included. The scoreboard then expects the status to rise one cycle after the boundary. A further window with pulses just under the limit in two consecutive windows confirms that nothing carries across the clear.

// File: rtl/gat_pkg.sv
package gat_pkg;
  // Base window length in core clocks at nominal settings
  localparam int unsigned BASE_NOMINAL    = 1344;
  // Number of base windows per global window at nominal settings
  localparam int unsigned GLOBAL_NOMINAL  = 16384;
  // Clean-window hold lengths for the two modes
  localparam int unsigned HOLD_LONG_DEF   = 16;
  localparam int unsigned HOLD_SHORT_DEF  = 2;

  // Width of a counter able to reach n-1 (minimum 1 bit)
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/gat_rst_sync.sv
module gat_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_n = sync_q;
endmodule

// File: rtl/gat_window_timer.sv
module gat_window_timer
  import gat_pkg::*;
#(
  parameter int unsigned BASE_CYCLES  = BASE_NOMINAL,
  parameter int unsigned GLOBAL_BASES = GLOBAL_NOMINAL
) (
  input  logic clk,
  input  logic rst_n,
  output logic win_end
);
  localparam int unsigned BW = cnt_width(BASE_CYCLES);
  localparam int unsigned GW = cnt_width(GLOBAL_BASES);
  localparam logic [BW-1:0] BASE_LAST = BW'(BASE_CYCLES - 1);
  localparam logic [GW-1:0] GLOB_LAST = GW'(GLOBAL_BASES - 1);

  logic [BW-1:0] base_q, base_d;
  logic [GW-1:0] glob_q, glob_d;
  logic          base_tick;

  always_comb begin
    base_tick = (base_q == BASE_LAST);
    base_d    = base_tick ? '0 : base_q + 1'b1;
    glob_d    = (glob_q == GLOB_LAST) ? '0 : glob_q + 1'b1;
    win_end   = base_tick && (glob_q == GLOB_LAST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
    end else begin
      base_q <= base_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glob_q <= '0;
    end else if (base_tick) begin
      glob_q <= glob_d;
    end
  end
endmodule

// File: rtl/gat_rank_counter.sv
module gat_rank_counter #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act,
  input  logic             win_end,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] count,
  output logic             over
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] count_q, count_inc, count_d;

  always_comb begin
    count_inc = (act && (count_q != CNT_MAX)) ? count_q + 1'b1 : count_q;
    over      = (count_inc > limit);
    count_d   = win_end ? '0 : count_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else begin
      count_q <= count_d;
    end
  end

  assign count = count_q;
endmodule

// File: rtl/gat_hold_fsm.sv
module gat_hold_fsm
  import gat_pkg::*;
#(
  parameter int unsigned HOLD_LONG  = HOLD_LONG_DEF,
  parameter int unsigned HOLD_SHORT = HOLD_SHORT_DEF,
  localparam int unsigned RUN_W     = cnt_width(HOLD_LONG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             win_end,
  input  logic             any_over,
  input  logic             short_hold,
  output logic             status,
  output logic [RUN_W-1:0] run_cnt
);
  localparam logic [RUN_W-1:0] LONG_LAST  = RUN_W'(HOLD_LONG - 1);
  localparam logic [RUN_W-1:0] SHORT_LAST = RUN_W'(HOLD_SHORT - 1);

  logic             status_q, status_d;
  logic [RUN_W-1:0] run_q, run_d;
  logic [RUN_W-1:0] run_last;

  always_comb begin
    run_last = short_hold ? SHORT_LAST : LONG_LAST;
    status_d = status_q;
    run_d    = run_q;
    if (any_over) begin
      status_d = 1'b1;
      run_d    = '0;
    end else if (status_q) begin
      if (run_q >= run_last) begin
        status_d = 1'b0;
        run_d    = '0;
      end else begin
        run_d    = run_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= 1'b0;
      run_q    <= '0;
    end else if (win_end) begin
      status_q <= status_d;
      run_q    <= run_d;
    end
  end

  assign status  = status_q;
  assign run_cnt = run_q;
endmodule

// File: rtl/gact_throttle.sv
module gact_throttle
  import gat_pkg::*;
#(
  parameter int unsigned NUM_RANKS    = 4,
  parameter int unsigned CNT_W        = 24,
  parameter int unsigned BASE_CYCLES  = BASE_NOMINAL,
  parameter int unsigned GLOBAL_BASES = GLOBAL_NOMINAL,
  parameter int unsigned HOLD_LONG    = HOLD_LONG_DEF,
  parameter int unsigned HOLD_SHORT   = HOLD_SHORT_DEF
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_RANKS-1:0] act_pulse,
  input  logic [CNT_W-1:0]     act_limit,
  input  logic                 short_hold,
  output logic                 gbl_throttle,
  output logic                 use_high_limit
);
  localparam int unsigned RUN_W = cnt_width(HOLD_LONG);

  logic                       rst_sync_n;
  logic                       win_end;
  logic [NUM_RANKS-1:0]       over_vec;
  logic [NUM_RANKS*CNT_W-1:0] cnt_flat;
  logic                       any_over;
  logic                       status;
  logic [RUN_W-1:0]           run_cnt;

  gat_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  gat_window_timer #(
    .BASE_CYCLES  (BASE_CYCLES),
    .GLOBAL_BASES (GLOBAL_BASES)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .win_end (win_end)
  );

  for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
    gat_rank_counter #(
      .CNT_W (CNT_W)
    ) u_cnt (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .act     (act_pulse[r]),
      .win_end (win_end),
      .limit   (act_limit),
      .count   (cnt_flat[r*CNT_W +: CNT_W]),
      .over    (over_vec[r])
    );
  end

  // Only the window-end compare matters; mid-window over flags are ignored
  assign any_over = win_end && (|over_vec);

  gat_hold_fsm #(
    .HOLD_LONG  (HOLD_LONG),
    .HOLD_SHORT (HOLD_SHORT)
  ) u_hold (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .win_end    (win_end),
    .any_over   (any_over),
    .short_hold (short_hold),
    .status     (status),
    .run_cnt    (run_cnt)
  );

  assign gbl_throttle   = status;
  assign use_high_limit = status;
endmodule

// File: rtl/gact_throttle_chk.sv
module gact_throttle_chk #(
  parameter int unsigned NUM_RANKS  = 4,
  parameter int unsigned CNT_W      = 24,
  parameter int unsigned HOLD_LONG  = 16,
  parameter int unsigned HOLD_SHORT = 2,
  parameter int unsigned RUN_W      = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       win_end,
  input logic                       any_over,
  input logic                       short_hold,
  input logic                       gbl_throttle,
  input logic [RUN_W-1:0]           run_cnt,
  input logic [NUM_RANKS*CNT_W-1:0] cnt_flat
);
  logic run_at_last;
  assign run_at_last = short_hold ? (run_cnt >= RUN_W'(HOLD_SHORT - 1))
                                  : (run_cnt >= RUN_W'(HOLD_LONG - 1));

  // R2
  status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !win_end |=> $stable(gbl_throttle));

  // R4
  status_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gbl_throttle) |-> $past(win_end && any_over));

  // R10
  run_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_end && any_over) |=> (gbl_throttle && run_cnt == '0));

  // R8
  status_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gbl_throttle) |-> $past(win_end && !any_over && run_at_last));

  // R7
  rank_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_end |=> (cnt_flat == '0));

  // R1
  run_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gbl_throttle |-> (run_cnt == '0));

  for (genvar r = 0; r < NUM_RANKS; r++) begin : g_mono
    // R6
    rank_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !win_end |=> (cnt_flat[r*CNT_W +: CNT_W] >= $past(cnt_flat[r*CNT_W +: CNT_W])));
  end
endmodule

bind gact_throttle gact_throttle_chk #(
  .NUM_RANKS  (NUM_RANKS),
  .CNT_W      (CNT_W),
  .HOLD_LONG  (HOLD_LONG),
  .HOLD_SHORT (HOLD_SHORT),
  .RUN_W      (RUN_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .win_end      (win_end),
  .any_over     (any_over),
  .short_hold   (short_hold),
  .gbl_throttle (gbl_throttle),
  .run_cnt      (run_cnt),
  .cnt_flat     (cnt_flat)
);

// File: tb/gact_throttle_bench.sv
module gact_throttle_bench;
  localparam int NR    = 4;
  localparam int CW    = 4;
  localparam int BASE  = 8;
  localparam int GB    = 4;
  localparam int W     = BASE * GB;
  localparam int LONG  = 16;
  localparam int SHORT = 2;
  localparam int CMAX  = (1 << CW) - 1;

  typedef struct {
    logic  st;
    string req;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NR-1:0] act;
  logic [CW-1:0] limit;
  logic          short_hold;
  logic          gbl;
  logic          use_high;

  int   checks = 0;
  int   errors = 0;
  exp_t exp_q[$];
  logic model_st = 1'b0;
  int   model_run = 0;
  logic last_exp = 1'b0;

  always #5 clk = ~clk;

  gact_throttle #(
    .NUM_RANKS    (NR),
    .CNT_W        (CW),
    .BASE_CYCLES  (BASE),
    .GLOBAL_BASES (GB),
    .HOLD_LONG    (LONG),
    .HOLD_SHORT   (SHORT)
  ) u_gact_throttle (
    .clk            (clk),
    .rst_n          (rst_n),
    .act_pulse      (act),
    .act_limit      (limit),
    .short_hold     (short_hold),
    .gbl_throttle   (gbl),
    .use_high_limit (use_high)
  );

  task automatic check(input string req, input logic actual, input logic expected);
    checks++;
    if (actual !== expected) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, actual, expected, $time);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  // Driver: model the window outcome, queue it, then drive one window of pulses
  task automatic drive_window(input int n0, input int n1, input int n2, input int n3,
                              input string req, input bit tail = 1'b0);
    int   nn[NR];
    logic over;
    int   hold;
    exp_t e;
    nn[0] = n0; nn[1] = n1; nn[2] = n2; nn[3] = n3;
    over = 1'b0;
    for (int r = 0; r < NR; r++) begin
      int sat;
      sat = (nn[r] > CMAX) ? CMAX : nn[r];
      if (sat > int'(limit)) over = 1'b1;
    end
    hold = short_hold ? SHORT : LONG;
    if (over) begin
      model_st  = 1'b1;
      model_run = 0;
    end else if (model_st) begin
      if (model_run >= hold - 1) begin
        model_st  = 1'b0;
        model_run = 0;
      end else begin
        model_run++;
      end
    end
    e.st  = model_st;
    e.req = req;
    exp_q.push_back(e);
    for (int c = 0; c < W; c++) begin
      for (int r = 0; r < NR; r++)
        act[r] = tail ? (c >= W - nn[r]) : (c < nn[r]);
      @(negedge clk);
    end
    act = '0;
  endtask

  // Monitor: mid-window stability and end-of-window comparison
  initial begin
    wait (rst_n === 1'b1);
    @(negedge clk);
    @(negedge clk);
    forever begin
      exp_t e;
      repeat (W / 2) @(negedge clk);
      check("R2 mid-window status", gbl, last_exp);
      repeat (W - W / 2) @(negedge clk);
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        check(e.req, gbl, e.st);
        check({e.req, " R11 select"}, use_high, e.st);
        last_exp = e.st;
      end
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog expired");
    summary();
    $finish;
  end

  initial begin
    rst_n      = 1'b0;
    act        = '0;
    limit      = CW'(5);
    short_hold = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 reset status", gbl, 1'b0);
    check("R1 reset select", use_high, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);

    drive_window(0, 0, 0, 0, "R1 idle window");
    drive_window(0, 0, 5, 0, "R5 equal to limit");
    drive_window(0, 6, 0, 0, "R4 over sets status");
    drive_window(0, 0, 0, 0, "R9 first clean");
    drive_window(0, 0, 0, 0, "R9 second clean clears");
    drive_window(7, 0, 0, 0, "R4 set again");
    drive_window(0, 0, 0, 0, "R10 clean one");
    drive_window(0, 0, 0, 9, "R10 over restarts run");
    drive_window(0, 0, 0, 0, "R10 clean after restart");
    drive_window(0, 0, 0, 0, "R10 full hold clears");

    short_hold = 1'b0;
    drive_window(0, 8, 0, 0, "R8 set for long hold");
    for (int k = 1; k <= LONG; k++)
      drive_window(0, 0, 0, 0, (k == LONG) ? "R8 16th clean clears" : "R8 still holding");

    drive_window(0, 4, 0, 0, "R7 first half no carry");
    drive_window(0, 4, 0, 0, "R7 second half no carry");

    short_hold = 1'b1;
    drive_window(6, 0, 0, 0, "R3 last-cycle pulse counted", 1'b1);
    drive_window(0, 0, 0, 0, "R9 clean");
    drive_window(0, 0, 0, 0, "R9 clears");

    limit = CW'(14);
    drive_window(0, 0, 20, 0, "R6 saturating count over limit");
    drive_window(0, 0, 0, 0, "R6 clean");
    drive_window(0, 0, 0, 0, "R6 clears");

    repeat (4) @(negedge clk);
    summary();
    $finish;
  end
endmodule